// File: doc/BRIEF.md
# Size-Weighted Eviction Chooser

This unit picks which way of one set in a compressed, set-associative cache is evicted. Each way presents a re-reference prediction value and the compressed size of its block in bytes. The unit turns the prediction value into an importance figure and weighs it against the block's size. The way whose importance per byte is lowest becomes the victim. Large blocks that are unlikely to be reused go first. Small blocks are protected, because one large incoming block could otherwise force several of them out.

The cache controller presents the set's state and pulses a request. The unit captures the whole set on that edge. It then walks the ways one per cycle, in ascending index order. When the last way has been weighed, it raises a one-cycle done strobe with the chosen way on the victim output. The victim output holds that value until the next search completes. Ways that hold no block are always used before any occupied way.

Top module: `size_victim_sel`

## Requirements
- R1: With every way valid, the victim is the way with the smallest importance/size, where importance = (2^RRPV_W − 1) − rrpv and size is the way's compressed size in bytes (1 to 64, never 0 for a valid way). Way k's prediction value sits in rrpv_i[k*RRPV_W +: RRPV_W] and its size in size_i[k*SIZE_W +: SIZE_W].
- R2: The comparison is exact on the rational values. A way with importance 2 and size 7 beats ways with importance 1 and size 3, although integer quotients would call them equal.
- R3: If any way has valid_i[k] = 0, the victim is the lowest-index such way, whatever the other ways hold.
- R4: When two or more ways share the smallest value, the lowest index among them wins. This includes equal fractions with different terms, such as 1/4 and 2/8.
- R5: A valid way whose prediction value is at its maximum has importance 0. The lowest-index such way is chosen.
- R6: A request sampled on a rising edge, with the unit idle, yields done_o high for exactly one cycle. The strobe comes after the WAYS-th following rising edge.
- R7: The set state is captured on the accepting edge. Changes to valid_i, rrpv_i or size_i during a search do not affect its result.
- R8: A request arriving while a search is running is ignored. The running search ends on its original schedule and yields one done strobe.
- R9: While reset is applied, done_o is 0 and victim_o is 0.
- R10: victim_o changes only together with a done strobe, and holds its value between searches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Start a victim search for the presented set |
| valid_i | input | WAYS | Per-way occupied flag |
| rrpv_i | input | WAYS*RRPV_W | Per-way re-reference prediction values, way 0 in the low bits |
| size_i | input | WAYS*SIZE_W | Per-way compressed size in bytes, way 0 in the low bits |
| victim_o | output | IDX_W | Index of the chosen way |
| done_o | output | 1 | One-cycle strobe: victim_o holds a new result |

## Verification
The bench targets sets where a plain quotient or a plain priority ranking picks the wrong way. In one, a larger block with higher importance still has the lower value; a truncating divider would fall back to way 0. In another, two fractions with different terms are equal; a non-strict compare would move the choice to the higher index. Sets with scattered empty ways, or only the top way empty, catch a chooser that lets an occupied way win or keeps the last empty way seen. Inputs are changed in the middle of a search and a second request is sent during a search. These catch a design that reads live inputs or restarts its scan, and either would return the wrong way or finish late.

// File: rtl/svs_pkg.sv
package svs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } svs_state_e;
endpackage

// File: rtl/svs_rst_sync.sv
module svs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/svs_importance.sv
module svs_importance #(
  parameter int WAYS   = 8,
  parameter int RRPV_W = 2
) (
  input  logic [WAYS*RRPV_W-1:0] rrpv_i,
  output logic [WAYS*RRPV_W-1:0] imp_o
);
  localparam logic [RRPV_W-1:0] RRPV_MAX = {RRPV_W{1'b1}};

  for (genvar k = 0; k < WAYS; k++) begin : g_way
    assign imp_o[k*RRPV_W +: RRPV_W] = RRPV_MAX - rrpv_i[k*RRPV_W +: RRPV_W];
  end
endmodule

// File: rtl/svs_better.sv
module svs_better #(
  parameter int RRPV_W = 2,
  parameter int SIZE_W = 7
) (
  input  logic [RRPV_W-1:0] cand_p_i,
  input  logic [SIZE_W-1:0] cand_s_i,
  input  logic [RRPV_W-1:0] best_p_i,
  input  logic [SIZE_W-1:0] best_s_i,
  output logic              better_o
);
  localparam int PROD_W = RRPV_W + SIZE_W;

  logic [PROD_W-1:0] lhs;
  logic [PROD_W-1:0] rhs;

  // cand_p/cand_s < best_p/best_s, rewritten without a divider
  assign lhs      = PROD_W'(cand_p_i) * PROD_W'(best_s_i);
  assign rhs      = PROD_W'(best_p_i) * PROD_W'(cand_s_i);
  assign better_o = (lhs < rhs);
endmodule

// File: rtl/size_victim_sel.sv
module size_victim_sel
  import svs_pkg::*;
#(
  parameter  int WAYS   = 8,
  parameter  int RRPV_W = 2,
  parameter  int SIZE_W = 7,
  localparam int IDX_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic [WAYS-1:0]        valid_i,
  input  logic [WAYS*RRPV_W-1:0] rrpv_i,
  input  logic [WAYS*SIZE_W-1:0] size_i,
  output logic [IDX_W-1:0]       victim_o,
  output logic                   done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WAYS - 1);

  logic rst_s_n;

  svs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  // captured set state
  logic [WAYS-1:0]        valid_q;
  logic [WAYS*RRPV_W-1:0] rrpv_q;
  logic [WAYS*SIZE_W-1:0] size_q;
  logic [WAYS*RRPV_W-1:0] imp_w;

  // scan state
  svs_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              have_q, have_d;
  logic              binv_q, binv_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic [RRPV_W-1:0] bp_q, bp_d;
  logic [SIZE_W-1:0] bs_q, bs_d;
  logic [IDX_W-1:0]  victim_q, victim_d;
  logic              done_q, done_d;

  logic              accept;
  logic              is_last;
  logic              cur_valid;
  logic [RRPV_W-1:0] cur_p;
  logic [SIZE_W-1:0] cur_s;
  logic              cur_better;
  logic              take;

  svs_importance #(.WAYS(WAYS), .RRPV_W(RRPV_W)) u_imp (
    .rrpv_i (rrpv_q),
    .imp_o  (imp_w)
  );

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign is_last   = (idx_q == LAST_IDX);
  assign cur_valid = valid_q[idx_q];
  assign cur_p     = imp_w[idx_q*RRPV_W +: RRPV_W];
  assign cur_s     = size_q[idx_q*SIZE_W +: SIZE_W];

  svs_better #(.RRPV_W(RRPV_W), .SIZE_W(SIZE_W)) u_cmp (
    .cand_p_i (cur_p),
    .cand_s_i (cur_s),
    .best_p_i (bp_q),
    .best_s_i (bs_q),
    .better_o (cur_better)
  );

  // an empty way wins unless an earlier empty way already holds the slot;
  // a valid way wins only against another valid way with strictly larger value
  always_comb begin
    if (!cur_valid) take = !binv_q;
    else            take = !have_q || (!binv_q && cur_better);
  end

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    have_d   = have_q;
    binv_d   = binv_q;
    bidx_d   = bidx_q;
    bp_d     = bp_q;
    bs_d     = bs_q;
    victim_d = victim_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = ST_SCAN;
          idx_d   = '0;
          have_d  = 1'b0;
          binv_d  = 1'b0;
        end
      end
      ST_SCAN: begin
        if (take) begin
          have_d = 1'b1;
          binv_d = !cur_valid;
          bidx_d = idx_q;
          bp_d   = cur_p;
          bs_d   = cur_s;
        end
        if (is_last) begin
          state_d  = ST_IDLE;
          victim_d = take ? idx_q : bidx_q;
          done_d   = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      have_q   <= 1'b0;
      binv_q   <= 1'b0;
      bidx_q   <= '0;
      bp_q     <= '0;
      bs_q     <= '0;
      victim_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      have_q   <= have_d;
      binv_q   <= binv_d;
      bidx_q   <= bidx_d;
      bp_q     <= bp_d;
      bs_q     <= bs_d;
      victim_q <= victim_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      valid_q <= '0;
      rrpv_q  <= '0;
      size_q  <= '0;
    end else if (accept) begin
      valid_q <= valid_i;
      rrpv_q  <= rrpv_i;
      size_q  <= size_i;
    end
  end

  assign victim_o = victim_q;
  assign done_o   = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !done_o); // R6

  AST_EMPTY_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done_o && !(&valid_q)) |-> !valid_q[victim_o]); // R3

  AST_VICTIM_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (victim_o != $past(victim_o)) |-> done_o); // R10

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_SCAN && !is_last) |=> (state_q == ST_SCAN && idx_q == $past(idx_q) + 1'b1)); // R8

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_IDLE && req_i) |=> (state_q == ST_SCAN && idx_q == '0)); // R6

  AST_VALID_SIZE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_SCAN && cur_valid) |-> (cur_s != '0)); // R1
endmodule

// File: tb/size_victim_sel_bench.sv
`timescale 1ns/1ps
module size_victim_sel_bench;
  localparam int WAYS   = 8;
  localparam int RRPV_W = 2;
  localparam int SIZE_W = 7;
  localparam int IDX_W  = 3;
  localparam int NVEC   = 8;

  typedef struct packed {
    logic [WAYS-1:0]        v;
    logic [WAYS*RRPV_W-1:0] r;
    logic [WAYS*SIZE_W-1:0] s;
    logic [IDX_W-1:0]       e;
  } vec_t;

  // fields are written way 7 first, way 0 last
  localparam vec_t VT [NVEC] = '{
    '{v: 8'hFF, r: 16'h0000,
      s: {7'd48,7'd1,7'd2,7'd4,7'd32,7'd64,7'd16,7'd8}, e: 3'd2},             // R1
    '{v: 8'hFF, r: {2'd1,2'd2,2'd1,2'd0,2'd1,2'd2,2'd1,2'd0},
      s: {8{7'd16}}, e: 3'd2},                                                // R4
    '{v: 8'hFF, r: {2'd2,2'd2,2'd1,2'd2,2'd2,2'd2,2'd2,2'd2},
      s: {7'd3,7'd3,7'd7,7'd3,7'd3,7'd3,7'd3,7'd3}, e: 3'd5},                 // R2
    '{v: 8'b1010_1011, r: 16'h0000, s: {8{7'd8}}, e: 3'd2},                   // R3
    '{v: 8'hFF, r: {2'd0,2'd3,2'd0,2'd0,2'd3,2'd0,2'd0,2'd0},
      s: {8{7'd1}}, e: 3'd3},                                                 // R5
    '{v: 8'h7F, r: 16'h0000, s: {8{7'd1}}, e: 3'd7},                          // R3
    '{v: 8'hFF, r: 16'h5555,
      s: {7'd63,7'd14,7'd12,7'd10,7'd8,7'd6,7'd4,7'd2}, e: 3'd7},             // R1
    '{v: 8'hFF, r: {2'd0,2'd0,2'd0,2'd1,2'd0,2'd0,2'd2,2'd0},
      s: {7'd4,7'd4,7'd4,7'd8,7'd4,7'd4,7'd4,7'd4}, e: 3'd1}                  // R4
  };

  logic                   clk;
  logic                   rst_n;
  logic                   req_i;
  logic [WAYS-1:0]        valid_i;
  logic [WAYS*RRPV_W-1:0] rrpv_i;
  logic [WAYS*SIZE_W-1:0] size_i;
  logic [IDX_W-1:0]       victim_o;
  logic                   done_o;

  int tests;
  int fails;
  bit finished;

  size_victim_sel #(.WAYS(WAYS), .RRPV_W(RRPV_W), .SIZE_W(SIZE_W)) u_size_victim_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .valid_i  (valid_i),
    .rrpv_i   (rrpv_i),
    .size_i   (size_i),
    .victim_o (victim_o),
    .done_o   (done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t t);
    valid_i = t.v;
    rrpv_i  = t.r;
    size_i  = t.s;
  endtask

  // start a search at a negedge; return edges until done and the victim
  task automatic run(input vec_t t, output int lat, output int vic);
    @(negedge clk);
    apply(t);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    lat = 0;
    vic = -1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (done_o) begin
        lat = n;
        vic = int'(victim_o);
        break;
      end
    end
  endtask

  initial begin
    tests    = 0;
    fails    = 0;
    finished = 0;
    req_i    = 1'b0;
    valid_i  = '0;
    rrpv_i   = '0;
    size_i   = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 done in reset", int'(done_o), 0);
    chk("R9 victim in reset", int'(victim_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      int lat, vic;
      run(VT[i], lat, vic);
      chk($sformatf("R1/R2/R3/R4/R5 vector %0d victim", i), vic, int'(VT[i].e));
      chk($sformatf("R6 vector %0d latency", i), lat, WAYS);
      @(negedge clk);
      chk($sformatf("R6 vector %0d done width", i), int'(done_o), 0);
    end

    // R7: inputs changed during the search do not alter the result
    begin
      int lat, vic;
      @(negedge clk);
      apply(VT[0]);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      apply(VT[4]);
      lat = 0;
      vic = -1;
      for (int n = 1; n <= 40; n++) begin
        @(negedge clk);
        if (n == 3) apply(VT[5]);
        if (done_o) begin
          lat = n;
          vic = int'(victim_o);
          break;
        end
      end
      chk("R7 captured state victim", vic, 2);
    end

    // R8: second request mid-search is ignored
    begin
      int lat, dones, vic;
      @(negedge clk);
      apply(VT[2]);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      lat = 0;
      dones = 0;
      vic = -1;
      for (int n = 1; n <= 3 * WAYS; n++) begin
        if (n == 3) begin
          apply(VT[3]);
          req_i = 1'b1;
        end
        @(negedge clk);
        if (n == 3) req_i = 1'b0;
        if (done_o) begin
          dones++;
          if (lat == 0) begin
            lat = n;
            vic = int'(victim_o);
          end
        end
      end
      chk("R8 latency with extra request", lat, WAYS);
      chk("R8 single done", dones, 1);
      chk("R8 victim of first request", vic, 5);
    end

    // R10: victim holds with no request while inputs move
    begin
      bit moved;
      moved = 0;
      for (int n = 0; n < 6; n++) begin
        apply(VT[n % NVEC]);
        @(negedge clk);
        if (victim_o != 3'd5 || done_o) moved = 1;
      end
      chk("R10 victim held between searches", int'(moved), 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule